// File: doc/BRIEF.md
# Short-Circuit Fault Timer and Hiccup Sequencer

This block supervises the gate drive of a current-mode switching controller. It sequences start-up against two digital supply indications: one reports that the supply has crossed the start threshold, and the other that it has fallen under the stop threshold. Each time the drive is first permitted, the block asks for a soft-start ramp of fixed length. It also watches a flag that the current comparator raises in every switching cycle that meets the maximum peak-current limit.

If the limit flag stays high without a break for a programmed number of clock cycles, the block removes the drive enable. A static mode strap then decides what happens next. In auto-recovery mode, the block asks the supply to discharge and ignores the start indication until the supply has fallen under the stop threshold. It then waits for a fresh start indication and retries with a new soft-start. In latched mode, the drive stays off whatever the supply indications do, until the block is reset, which stands for a complete power cycle.

The fault window and the soft-start length are counted in clock cycles and are parameters. At a 50 MHz clock, roughly 100 ms and 4 ms correspond to five million and two hundred thousand cycles.

Top module: `scp_supervisor`

## Requirements
- R1: While reset is high and on the first cycle after it, drive_en, softstart_req and discharge_req are all low.
- R2: From the off state, the drive is enabled only when supply_ok_start is high and supply_low is low at a clock edge. Until then all outputs stay low.
- R3: When the drive is enabled from the off state, drive_en and softstart_req both go high on the next cycle. softstart_req stays high for exactly SS_CYCLES cycles, then falls while drive_en stays high.
- R4: When ilim_hit is high for FAULT_CYCLES consecutive clock edges while the drive is enabled, drive_en falls after the last of those edges.
- R5: A single low cycle of ilim_hit resets the fault count, so a further full FAULT_CYCLES consecutive high cycles are needed to stop the drive.
- R6: In auto-recovery mode (latch_mode low), a fault turns drive_en low and discharge_req high. supply_ok_start is then ignored while supply_low stays low.
- R7: In auto-recovery mode, supply_low high during the discharge ends it: all outputs go low. A later start indication begins a new soft-start exactly as in R3.
- R8: In latched mode (latch_mode high, sampled when the fault expires), a fault leaves all three outputs low. No combination of supply indications changes that; only reset clears it.
- R9: supply_low high while driving, whether in soft-start or in normal run, clears drive_en and softstart_req on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| ilim_hit | input | 1 | Peak-current limit reached in this switching cycle |
| supply_ok_start | input | 1 | Supply is above the start threshold |
| supply_low | input | 1 | Supply is below the stop threshold |
| latch_mode | input | 1 | 1 = latch off on fault, 0 = auto-recovery hiccup |
| drive_en | output | 1 | Gate pulses permitted |
| softstart_req | output | 1 | Soft-start ramp requested |
| discharge_req | output | 1 | Supply discharge requested during hiccup |

## Verification
The outputs decode a registered state, so every result shows one cycle after the edge that samples its cause. A start indication gives drive_en and softstart_req on the next cycle, and soft-start ends SS_CYCLES edges after it began. A fault shows after the FAULT_CYCLES-th consecutive high edge of the limit flag, and a low-supply or discharge-end event shows after one edge. The bench changes inputs just after a rising edge, advances a precise number of edges, and samples 2 ns later. Each check therefore sits on the first cycle the new value is due, or on the last cycle before it, which catches off-by-one errors in both timers.

// File: rtl/scp_pkg.sv
package scp_pkg;

    typedef enum logic [2:0] {
        ST_OFF       = 3'd0,
        ST_SOFTSTART = 3'd1,
        ST_RUN       = 3'd2,
        ST_DISCHARGE = 3'd3,
        ST_LATCHED   = 3'd4
    } scp_state_e;

    typedef struct packed {
        logic drive_en;
        logic softstart_req;
        logic discharge_req;
    } scp_out_t;

    // Counter width for a limit, never zero
    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction

    function automatic scp_out_t decode_state(input scp_state_e st);
        scp_out_t o;
        o.drive_en      = (st == ST_SOFTSTART) || (st == ST_RUN);
        o.softstart_req = (st == ST_SOFTSTART);
        o.discharge_req = (st == ST_DISCHARGE);
        return o;
    endfunction

endpackage

// File: rtl/scp_fault_timer.sv
module scp_fault_timer #(
    parameter int unsigned LIMIT = 5_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic ilim_hit,
    output logic expire
);
    localparam int unsigned W = scp_pkg::cnt_width(LIMIT);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !enable || !ilim_hit)
            cnt <= '0;
        else if (cnt != LAST)
            cnt <= cnt + 1'b1;
    end

    assign expire = enable && ilim_hit && (cnt == LAST);

    // R5: any low cycle of the flag restarts the window
    a_r5_clear_on_drop: assert property (@(posedge clk) disable iff (rst)
        (enable && !ilim_hit) |=> (cnt == '0));

    // R4: count never runs past the window
    a_r4_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

endmodule

// File: rtl/scp_softstart_timer.sv
module scp_softstart_timer #(
    parameter int unsigned LENGTH = 200_000
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic done
);
    localparam int unsigned W = scp_pkg::cnt_width(LENGTH);
    localparam logic [W-1:0] LAST = W'(LENGTH - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !active)
            cnt <= '0;
        else if (cnt != LAST)
            cnt <= cnt + 1'b1;
    end

    assign done = active && (cnt == LAST);

    // R3: ramp counter starts from zero on each entry
    a_r3_fresh_start: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> (cnt == '0));

    a_r3_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

endmodule

// File: rtl/scp_sequencer.sv
module scp_sequencer
    import scp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       supply_ok_start,
    input  logic       supply_low,
    input  logic       latch_mode,
    input  logic       ss_done,
    input  logic       fault_expire,
    output scp_state_e state,
    output scp_out_t   outs
);
    scp_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:
                if (supply_ok_start && !supply_low) state_nx = ST_SOFTSTART;
            ST_SOFTSTART: begin
                if (supply_low)        state_nx = ST_OFF;
                else if (fault_expire) state_nx = latch_mode ? ST_LATCHED : ST_DISCHARGE;
                else if (ss_done)      state_nx = ST_RUN;
            end
            ST_RUN: begin
                if (supply_low)        state_nx = ST_OFF;
                else if (fault_expire) state_nx = latch_mode ? ST_LATCHED : ST_DISCHARGE;
            end
            ST_DISCHARGE:
                if (supply_low) state_nx = ST_OFF;
            ST_LATCHED:
                state_nx = ST_LATCHED;
            default:
                state_nx = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_OFF;
        else     state <= state_nx;
    end

    assign outs = decode_state(state);

    // R2: no start indication keeps the block off
    a_r2_wait_start: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OFF && !supply_ok_start) |=> (state == ST_OFF));

    // R3: every enable of the drive begins with soft-start
    a_r3_rise_with_ss: assert property (@(posedge clk) disable iff (rst)
        $rose(outs.drive_en) |-> outs.softstart_req);

    // R6: discharge persists until the supply is low
    a_r6_discharge_hold: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DISCHARGE && !supply_low) |=> (state == ST_DISCHARGE));

    // R8: latch is only left through reset
    a_r8_latched_sticky: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LATCHED) |=> (state == ST_LATCHED));

    // R9: undervoltage removes drive on the next cycle
    a_r9_uvlo: assert property (@(posedge clk) disable iff (rst)
        (outs.drive_en && supply_low) |=> !outs.drive_en);

    a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(outs.discharge_req && outs.drive_en));

endmodule

// File: rtl/scp_supervisor.sv
module scp_supervisor #(
    parameter int unsigned FAULT_CYCLES = 5_000_000,
    parameter int unsigned SS_CYCLES    = 200_000
) (
    input  logic clk,
    input  logic rst,
    input  logic ilim_hit,
    input  logic supply_ok_start,
    input  logic supply_low,
    input  logic latch_mode,
    output logic drive_en,
    output logic softstart_req,
    output logic discharge_req
);
    import scp_pkg::*;

    scp_state_e state;
    scp_out_t   outs;
    logic       ss_done;
    logic       fault_expire;

    scp_sequencer i_seq (
        .clk             (clk),
        .rst             (rst),
        .supply_ok_start (supply_ok_start),
        .supply_low      (supply_low),
        .latch_mode      (latch_mode),
        .ss_done         (ss_done),
        .fault_expire    (fault_expire),
        .state           (state),
        .outs            (outs)
    );

    scp_softstart_timer #(.LENGTH(SS_CYCLES)) i_ss (
        .clk    (clk),
        .rst    (rst),
        .active (outs.softstart_req),
        .done   (ss_done)
    );

    scp_fault_timer #(.LIMIT(FAULT_CYCLES)) i_fault (
        .clk      (clk),
        .rst      (rst),
        .enable   (outs.drive_en),
        .ilim_hit (ilim_hit),
        .expire   (fault_expire)
    );

    assign drive_en      = outs.drive_en;
    assign softstart_req = outs.softstart_req;
    assign discharge_req = outs.discharge_req;

    // R1: outputs quiet right after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        $fell(rst) |-> !(drive_en || softstart_req || discharge_req));

endmodule

// File: tb/test_scp_supervisor.sv
module test_scp_supervisor;
    localparam int unsigned NF = 16;
    localparam int unsigned NS = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ilim_hit = 1'b0;
    logic supply_ok_start = 1'b0;
    logic supply_low = 1'b0;
    logic latch_mode = 1'b0;
    logic drive_en, softstart_req, discharge_req;

    int errors = 0;
    int checks = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    scp_supervisor #(.FAULT_CYCLES(NF), .SS_CYCLES(NS)) i_scp_supervisor (
        .clk             (clk),
        .rst             (rst),
        .ilim_hit        (ilim_hit),
        .supply_ok_start (supply_ok_start),
        .supply_low      (supply_low),
        .latch_mode      (latch_mode),
        .drive_en        (drive_en),
        .softstart_req   (softstart_req),
        .discharge_req   (discharge_req)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic expect_out(input string req, input logic d, input logic s, input logic q);
        checks++;
        if ({drive_en, softstart_req, discharge_req} !== {d, s, q}) begin
            errors++;
            $display("FAIL %s: drive/ss/dis actual=%b%b%b expected=%b%b%b",
                     req, drive_en, softstart_req, discharge_req, d, s, q);
        end
    endtask

    task automatic t_reset_and_wait;
        rst = 1'b1;
        step(3);
        expect_out("R1", 0, 0, 0);
        rst = 1'b0;
        step(1);
        expect_out("R1", 0, 0, 0);
        step(2);
        expect_out("R2", 0, 0, 0);
        supply_ok_start = 1'b1;
        supply_low = 1'b1;
        step(2);
        expect_out("R2", 0, 0, 0);
        supply_ok_start = 1'b0;
        supply_low = 1'b0;
        step(1);
    endtask

    task automatic t_power_up(input string req);
        supply_ok_start = 1'b1;
        step(1);
        expect_out(req, 1, 1, 0);
        supply_ok_start = 1'b0;
        step(NS - 1);
        expect_out(req, 1, 1, 0);
        step(1);
        expect_out(req, 1, 0, 0);
    endtask

    task automatic t_glitch_resets_timer;
        ilim_hit = 1'b1;
        step(NF - 1);
        expect_out("R5", 1, 0, 0);
        ilim_hit = 1'b0;
        step(1);
        ilim_hit = 1'b1;
        step(NF - 1);
        expect_out("R5", 1, 0, 0);
        ilim_hit = 1'b0;
        step(1);
        expect_out("R5", 1, 0, 0);
    endtask

    task automatic t_auto_hiccup;
        latch_mode = 1'b0;
        ilim_hit = 1'b1;
        step(NF - 1);
        expect_out("R4", 1, 0, 0);
        step(1);
        expect_out("R4", 0, 0, 1);
        ilim_hit = 1'b0;
        supply_ok_start = 1'b1;
        step(3);
        expect_out("R6", 0, 0, 1);
        supply_ok_start = 1'b0;
        supply_low = 1'b1;
        step(1);
        expect_out("R7", 0, 0, 0);
        supply_low = 1'b0;
        step(1);
        expect_out("R7", 0, 0, 0);
        t_power_up("R7");
    endtask

    task automatic t_uvlo;
        supply_low = 1'b1;
        step(1);
        expect_out("R9", 0, 0, 0);
        supply_low = 1'b0;
        supply_ok_start = 1'b1;
        step(1);
        expect_out("R9", 1, 1, 0);
        supply_ok_start = 1'b0;
        supply_low = 1'b1;
        step(1);
        expect_out("R9", 0, 0, 0);
        supply_low = 1'b0;
        step(1);
        t_power_up("R3");
    endtask

    task automatic t_latched;
        latch_mode = 1'b1;
        ilim_hit = 1'b1;
        step(NF);
        expect_out("R8", 0, 0, 0);
        ilim_hit = 1'b0;
        supply_low = 1'b1;
        step(2);
        expect_out("R8", 0, 0, 0);
        supply_low = 1'b0;
        supply_ok_start = 1'b1;
        step(3);
        expect_out("R8", 0, 0, 0);
        rst = 1'b1;
        step(1);
        rst = 1'b0;
        expect_out("R1", 0, 0, 0);
        step(1);
        expect_out("R8", 1, 1, 0);
        supply_ok_start = 1'b0;
    endtask

    initial begin
        t_reset_and_wait();
        t_power_up("R3");
        t_glitch_resets_timer();
        t_auto_hiccup();
        t_uvlo();
        t_latched();
        done_flag = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #4_000_000;
        if (!done_flag) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule